// File: doc/BRIEF.md
# Nine-Bit Address-Match Receive Interrupt Filter

This block sits behind a UART receiver that runs in nine-bit mode. There, the extra ninth bit of each character tells a station whether the character is an address or a data byte. For every received character the block decides whether the host should get a receive interrupt.

The decision depends on a two-bit filter policy and an eight-bit station address. The block keeps one piece of state, a match flag. That flag records whether the most recent address byte named this station. With the flag, a station can sleep through traffic meant for others and still wake for its own frames.

When nine-bit operation is switched off, the filter steps aside and every character interrupts. Deserialisation, buffering and line error detection are done elsewhere.

Top module: `mpf_irq_filter`

## Requirements
- R1: After reset, `irq_pulse` and `is_addr` are 0 and the match flag is clear.
- R2: `irq_pulse` is high for exactly one cycle, in the cycle after a `rx_valid` strobe. It is never high in a cycle that does not follow a strobe.
- R3: With `mp_en` = 0, every strobe raises `irq_pulse` whatever `rx_bit9` holds. `is_addr` is driven to 0 and the match flag keeps its value.
- R4: With `mp_en` = 1, `rx_bit9` = 1 marks an address byte and `rx_bit9` = 0 marks a data byte. `is_addr` shows the kind of the latest character from the cycle after its strobe until the next strobe.
- R5: Policy `filt_mode` = 2'b00 interrupts on every character, address or data.
- R6: Policy 2'b01 interrupts on address bytes only. Data bytes raise nothing.
- R7: Policy 2'b10 interrupts on an address byte equal to `cmp_addr`, and on every data byte that follows it. A non-matching address byte raises nothing, and neither do the data bytes after it.
- R8: Policy 2'b11 interrupts only on data bytes whose latest preceding address byte equalled `cmp_addr`. Address bytes never interrupt under this policy.
- R9: Each address byte received with `mp_en` = 1 updates the match flag, whatever the policy. A change of `filt_mode` alone leaves the flag unchanged.
- R10: Data bytes that arrive after reset, before any address byte, do not interrupt under policies 2'b10 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received data bits |
| rx_bit9 | input | 1 | Ninth bit: 1 = address byte, 0 = data byte |
| mp_en | input | 1 | Enables nine-bit address filtering |
| filt_mode | input | 2 | Interrupt policy select (see R5 to R8) |
| cmp_addr | input | 8 | This station's address |
| irq_pulse | output | 1 | One-cycle receive interrupt request |
| is_addr | output | 1 | Latest character was an address byte |

## Verification
The hardest case to reach is a policy change that happens while a match flag set earlier is still in force. The flag must survive the change, and also survive characters received with filtering switched off, and then decide the next data byte. Directed sequences set the flag under one policy, send address-looking characters with `mp_en` low, switch to another policy and check the next data byte. In the random stream, about half of all address bytes are drawn equal to `cmp_addr`, so runs of matched and unmatched frames alternate often.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    typedef enum logic [1:0] {
        FM_ALL  = 2'b00,
        FM_ADDR = 2'b01,
        FM_WIN  = 2'b10,
        FM_DATA = 2'b11
    } fmode_e;

    typedef struct packed {
        logic irq;
        logic is_addr;
        logic match;
    } mpf_state_t;

    localparam mpf_state_t MPF_RESET = '{irq: 1'b0, is_addr: 1'b0, match: 1'b0};

endpackage

// File: rtl/mpf_addr_cmp.sv
module mpf_addr_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] cmp_i,
    output logic          hit_o
);
    always_comb begin
        hit_o = (data_i == cmp_i);
    end
endmodule

// File: rtl/mpf_policy.sv
module mpf_policy
    import mpf_pkg::*;
(
    input  logic   mp_en_i,
    input  fmode_e mode_i,
    input  logic   bit9_i,
    input  logic   hit_i,
    input  logic   match_q_i,
    output logic   want_irq_o,
    output logic   upd_match_o,
    output logic   addr_now_o
);
    always_comb begin
        addr_now_o  = mp_en_i & bit9_i;
        upd_match_o = addr_now_o;
        if (!mp_en_i) begin
            want_irq_o = 1'b1;
        end else begin
            unique case (mode_i)
                FM_ALL:  want_irq_o = 1'b1;
                FM_ADDR: want_irq_o = bit9_i;
                FM_WIN:  want_irq_o = bit9_i ? hit_i : match_q_i;
                FM_DATA: want_irq_o = bit9_i ? 1'b0 : match_q_i;
                default: want_irq_o = 1'b0;
            endcase
        end
    end

    // R8
    always_comb begin
        if (mp_en_i && bit9_i && mode_i == FM_DATA)
            data_mode_addr_quiet_chk: assert (!want_irq_o);
    end
endmodule

// File: rtl/mpf_irq_filter.sv
module mpf_irq_filter
    import mpf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_bit9,
    input  logic          mp_en,
    input  logic [1:0]    filt_mode,
    input  logic [DW-1:0] cmp_addr,
    output logic          irq_pulse,
    output logic          is_addr
);
    mpf_state_t st_d, st_q;
    logic       hit, want_irq, upd_match, addr_now;

    mpf_addr_cmp #(.DW(DW)) u_cmp (
        .data_i (rx_data),
        .cmp_i  (cmp_addr),
        .hit_o  (hit)
    );

    mpf_policy u_pol (
        .mp_en_i     (mp_en),
        .mode_i      (fmode_e'(filt_mode)),
        .bit9_i      (rx_bit9),
        .hit_i       (hit),
        .match_q_i   (st_q.match),
        .want_irq_o  (want_irq),
        .upd_match_o (upd_match),
        .addr_now_o  (addr_now)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (rx_valid) begin
            st_d.irq     = want_irq;
            st_d.is_addr = addr_now;
            if (upd_match) st_d.match = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MPF_RESET;
        else        st_q <= st_d;
    end

    assign irq_pulse = st_q.irq;
    assign is_addr   = st_q.is_addr;

    // R2
    irq_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(rx_valid));

    // R3
    bypass_always_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && !mp_en) |-> irq_pulse);

    // R6
    addr_mode_data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && mp_en && !rx_bit9 && filt_mode == 2'b01) |-> !irq_pulse);

    // R9
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid && mp_en && rx_bit9) |-> $stable(st_q.match));

    // R4
    addr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && mp_en) |-> (is_addr == $past(rx_bit9)));
endmodule

// File: tb/sim_mpf_irq_filter.sv
`timescale 1ns/1ps
module sim_mpf_irq_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_bit9 = 1'b0;
    logic       mp_en = 1'b0;
    logic [1:0] filt_mode = '0;
    logic [7:0] cmp_addr = 8'h5A;
    logic       irq_pulse, is_addr;

    int  n_vec = 0;
    int  n_bad = 0;
    logic match_m = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    mpf_irq_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .mp_en(mp_en), .filt_mode(filt_mode),
        .cmp_addr(cmp_addr), .irq_pulse(irq_pulse), .is_addr(is_addr)
    );

    function automatic logic exp_irq(input logic mp, input logic [1:0] md,
                                     input logic b9, input logic hit, input logic m);
        if (!mp) return 1'b1;
        case (md)
            2'b00:   return 1'b1;
            2'b01:   return b9;
            2'b10:   return b9 ? hit : m;
            default: return b9 ? 1'b0 : m;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic send(input logic mp, input logic [1:0] md, input logic [7:0] d,
                        input logic b9, input string req);
        logic e_irq, e_addr, hit;
        @(negedge clk);
        mp_en = mp; filt_mode = md; rx_data = d; rx_bit9 = b9; rx_valid = 1'b1;
        hit    = (d == cmp_addr);
        e_irq  = exp_irq(mp, md, b9, hit, match_m);
        e_addr = mp & b9;
        @(negedge clk);
        rx_valid = 1'b0;
        check(req, "irq", irq_pulse, e_irq);
        check("R4", "is_addr", is_addr, e_addr);
        if (mp && b9) match_m = hit;
    endtask

    task automatic idle_check;
        @(negedge clk);
        check("R2", "irq after strobe gap", irq_pulse, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "irq at reset", irq_pulse, 1'b0);
        check("R1", "is_addr at reset", is_addr, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "irq after reset", irq_pulse, 1'b0);

        // R10: data before any address
        send(1, 2'b11, 8'h5A, 0, "R10");
        send(1, 2'b10, 8'h11, 0, "R10");
        idle_check();
        // R3: bypass, ninth bit ignored, match untouched
        send(0, 2'b11, 8'h5A, 1, "R3");
        send(1, 2'b11, 8'h22, 0, "R3");
        // R7 window policy
        send(1, 2'b10, 8'h5A, 1, "R7");
        send(1, 2'b10, 8'h01, 0, "R7");
        send(1, 2'b10, 8'h02, 0, "R7");
        idle_check();
        send(1, 2'b10, 8'h33, 1, "R7");
        send(1, 2'b10, 8'h5A, 0, "R7");
        // R8 data-after-match policy
        send(1, 2'b11, 8'h5A, 1, "R8");
        send(1, 2'b11, 8'h03, 0, "R8");
        send(1, 2'b11, 8'h44, 1, "R8");
        send(1, 2'b11, 8'h04, 0, "R8");
        // R6
        send(1, 2'b01, 8'h44, 1, "R6");
        send(1, 2'b01, 8'h05, 0, "R6");
        // R5
        send(1, 2'b00, 8'h06, 0, "R5");
        send(1, 2'b00, 8'h77, 1, "R5");
        // R9: set match under 01, switch to 11, flag kept across bypass traffic
        send(1, 2'b01, 8'h5A, 1, "R9");
        send(0, 2'b00, 8'h99, 1, "R9");
        send(1, 2'b11, 8'h07, 0, "R9");
        send(1, 2'b10, 8'h08, 0, "R9");
        idle_check();

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            logic b9, mp;
            logic [1:0] md;
            if ($urandom_range(0, 31) == 0) cmp_addr = 8'($urandom());
            b9 = ($urandom_range(0, 2) == 0);
            mp = ($urandom_range(0, 7) != 0);
            md = 2'($urandom_range(0, 3));
            d  = ($urandom_range(0, 1) == 0) ? cmp_addr : 8'($urandom());
            send(mp, md, d, b9, "R7");
            if ($urandom_range(0, 3) == 0) idle_check();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule